// File: doc/BRIEF.md
# DDR Read-Path Bank Timing Tracker

This block follows the read side of a DDR SDRAM controller bank by bank. It watches the command stream: open-row, read, read with automatic close, and close. From that stream it keeps a state for each bank (idle, open or locked) and a row-to-column delay count for each bank. From these it raises one flag per bank when a read to that bank would be legal.

When a read is accepted, the block predicts the clock cycles in which the read data will be on the bus. It marks the final cycle of that data window. If a close command reaches the bank of the burst in flight, the block stops the window early and pulses a notice that the burst was cut. A read with automatic close locks its bank until the burst has drained. Commands that the block refuses leave all state unchanged and produce a one-cycle protocol-error pulse.

The CAS latency, in whole controller cycles, and the burst-length code are captured only while reset is held. They keep those values until the next reset.

Top module: `ddr_rd_bank_tracker`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, every bank is idle and rd_legal, rd_valid, rd_last, burst_cut and proto_err are all low.
- R2: Command codes on cmd are 0 no-op, 1 open (activate), 2 read, 3 read with auto-close and 4 close (precharge); the codes 5 to 7 act as no-ops. An open to an idle bank makes it open; an open to a bank that is not idle is refused.
- R3: rd_legal[b] is high only when bank b is open, at least TRCD cycles have passed since the cycle of its open command, and no burst is in flight. A read or auto-close read is accepted only when rd_legal of its bank is high.
- R4: cfg_cas_lat and cfg_burst_code are sampled only while rst_n is low, and changes after reset have no effect. The latency is clamped into [CL_MIN, CL_MAX]. Burst code 0, 1 and 2 select bursts of 2, 4 and 8 words (1, 2 and 4 clock cycles); code 3 selects 8 words.
- R5: An accepted read issued in cycle t makes rd_valid high in cycles t+CL through t+CL+BL/2-1 and low otherwise, unless the burst is cut.
- R6: rd_last is high exactly in the final cycle of each uncut data window.
- R7: An accepted close to the bank of the burst in flight, in any cycle of that burst except its final data cycle, ends it: rd_valid is low from the next cycle on and burst_cut pulses high for that one next cycle. A close that falls on the final data cycle leaves the window whole and raises no burst_cut.
- R8: A close to an open bank makes it idle; a close to an idle bank is accepted and changes nothing.
- R9: An accepted auto-close read locks its bank; the bank becomes idle in the cycle after the final data cycle of its burst.
- R10: Any refused command (open to a non-idle bank, a read when rd_legal of its bank is low, or any command to a locked bank) makes proto_err high for exactly the next cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset; configuration is captured while low |
| cmd | input | 3 | Command code for this cycle |
| bank | input | BA_W (2) | Target bank of the command |
| cfg_cas_lat | input | CLW (3) | CAS latency in whole cycles, captured in reset |
| cfg_burst_code | input | 2 | Burst-length code, captured in reset |
| rd_legal | output | NUM_BANKS (4) | Per-bank read-legal flags |
| rd_valid | output | 1 | Read data is expected on the bus this cycle |
| rd_last | output | 1 | Final cycle of the read data window |
| burst_cut | output | 1 | One-cycle pulse after a close cut a burst short |
| proto_err | output | 1 | One-cycle pulse after a refused command |

## Verification
Two functions can fall in the same cycle. The first pair is the cut of a burst and the natural end of that burst. The bench times a close so that it lands exactly on the final data cycle, and it expects a whole window with no burst_cut. The second pair is the release of an auto-close lock and a new open to that bank. The bench sends an open on the final data cycle, which must be refused with proto_err, and sends it again one cycle later, when it must be accepted. A behavioural reference model in the bench judges every cycle of these and the other sequences, and it runs them again under several captured latencies and burst lengths, including values that have to be clamped.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_RDA = 3'd3,
      CMD_PRE = 3'd4
   } cmd_e;

   typedef enum logic [1:0] {
      BK_IDLE = 2'd0,
      BK_OPEN = 2'd1,
      BK_LOCK = 2'd2
   } bank_st_e;

   // largest burst in clock cycles (8 words, two per clock)
   localparam int MAX_BEATS = 4;
   localparam int BW        = $clog2(MAX_BEATS + 1);
endpackage

// File: rtl/ddr_rd_bank_slot.sv
module ddr_rd_bank_slot
   import ddr_rd_pkg::*;
#(
   parameter int TRCD = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     do_act,
   input  logic     do_pre,
   input  logic     do_lock,
   input  logic     do_release,
   output bank_st_e st,
   output logic     trcd_ok
);
   localparam int CW = $clog2(TRCD + 1);

   logic [CW-1:0] since_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= BK_IDLE;
         since_act <= '0;
      end else if (do_act) begin
         st        <= BK_OPEN;
         since_act <= CW'(1);
      end else if (do_lock) begin
         st        <= BK_LOCK;
      end else if (do_pre || do_release) begin
         st        <= BK_IDLE;
      end else if (st == BK_OPEN && since_act < CW'(TRCD)) begin
         since_act <= since_act + CW'(1);
      end
   end

   assign trcd_ok = (since_act >= CW'(TRCD));
endmodule

// File: rtl/ddr_rd_burst_seq.sv
module ddr_rd_burst_seq
   import ddr_rd_pkg::*;
#(
   parameter int BA_W = 2,
   parameter int CLW  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            start_ap,
   input  logic [BA_W-1:0] start_bank,
   input  logic            pre_req,
   input  logic [BA_W-1:0] pre_bank,
   input  logic [CLW-1:0]  cas_lat,
   input  logic [BW-1:0]   beats,
   output logic            busy,
   output logic            rd_valid,
   output logic            rd_last,
   output logic            burst_cut,
   output logic            rel_fire,
   output logic [BA_W-1:0] rel_bank
);
   logic [CLW-1:0]  lat_cnt;
   logic [BW-1:0]   beat_cnt;
   logic [BA_W-1:0] cur_bank;
   logic            cur_ap;
   logic            cut;

   assign rd_valid = busy && (lat_cnt == '0);
   assign rd_last  = rd_valid && (beat_cnt == BW'(1));
   assign cut      = pre_req && busy && (pre_bank == cur_bank) && !rd_last;
   assign rel_fire = rd_last && cur_ap;
   assign rel_bank = cur_bank;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         lat_cnt   <= '0;
         beat_cnt  <= '0;
         cur_bank  <= '0;
         cur_ap    <= 1'b0;
         burst_cut <= 1'b0;
      end else begin
         burst_cut <= cut;
         if (start) begin
            busy     <= 1'b1;
            lat_cnt  <= cas_lat - CLW'(1);
            beat_cnt <= beats;
            cur_bank <= start_bank;
            cur_ap   <= start_ap;
         end else if (cut) begin
            busy     <= 1'b0;
         end else if (busy) begin
            if (lat_cnt != '0)
               lat_cnt <= lat_cnt - CLW'(1);
            else if (beat_cnt == BW'(1))
               busy <= 1'b0;
            else
               beat_cnt <= beat_cnt - BW'(1);
         end
      end
   end
endmodule

// File: rtl/ddr_rd_bank_tracker.sv
module ddr_rd_bank_tracker
   import ddr_rd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int TRCD      = 3,
   parameter int CL_MIN    = 2,
   parameter int CL_MAX    = 4,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int CLW      = $clog2(CL_MAX + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           cmd,
   input  logic [BA_W-1:0]      bank,
   input  logic [CLW-1:0]       cfg_cas_lat,
   input  logic [1:0]           cfg_burst_code,
   output logic [NUM_BANKS-1:0] rd_legal,
   output logic                 rd_valid,
   output logic                 rd_last,
   output logic                 burst_cut,
   output logic                 proto_err
);
   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (TRCD < 1) begin : g_bad_trcd
         $error("TRCD must be at least 1");
      end
      if (CL_MIN < 1 || CL_MAX < CL_MIN) begin : g_bad_cl
         $error("CAS latency bounds are inconsistent");
      end
   endgenerate

   // configuration captured during reset
   logic [CLW-1:0] cl_q, cl_clamped;
   logic [BW-1:0]  beats_q, beats_dec;

   always_comb begin
      if (cfg_cas_lat < CLW'(CL_MIN))      cl_clamped = CLW'(CL_MIN);
      else if (cfg_cas_lat > CLW'(CL_MAX)) cl_clamped = CLW'(CL_MAX);
      else                                 cl_clamped = cfg_cas_lat;
      case (cfg_burst_code)
         2'd0:    beats_dec = BW'(1);
         2'd1:    beats_dec = BW'(2);
         default: beats_dec = BW'(MAX_BEATS);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cl_q    <= cl_clamped;
         beats_q <= beats_dec;
      end
   end

   // command acceptance
   logic [NUM_BANKS-1:0] idle_vec, lock_vec;
   logic                 is_act, is_rd, is_rda, is_pre, known;
   logic                 acc_act, acc_rd, acc_pre, reject;
   logic                 busy, rel_fire;
   logic [BA_W-1:0]      rel_bank;

   assign is_act  = (cmd == CMD_ACT);
   assign is_rd   = (cmd == CMD_RD);
   assign is_rda  = (cmd == CMD_RDA);
   assign is_pre  = (cmd == CMD_PRE);
   assign known   = is_act || is_rd || is_rda || is_pre;
   assign acc_act = is_act && idle_vec[bank];
   assign acc_rd  = (is_rd || is_rda) && rd_legal[bank];
   assign acc_pre = is_pre && !lock_vec[bank];
   assign reject  = known && !(acc_act || acc_rd || acc_pre);

   always_ff @(posedge clk) begin
      if (!rst_n) proto_err <= 1'b0;
      else        proto_err <= reject;
   end

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         bank_st_e st;
         logic     trcd_ok, hit;
         assign hit = (bank == BA_W'(b));

         ddr_rd_bank_slot #(.TRCD(TRCD)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_act     (acc_act && hit),
            .do_pre     (acc_pre && hit),
            .do_lock    (acc_rd && is_rda && hit),
            .do_release (rel_fire && rel_bank == BA_W'(b)),
            .st         (st),
            .trcd_ok    (trcd_ok)
         );

         assign idle_vec[b] = (st == BK_IDLE);
         assign lock_vec[b] = (st == BK_LOCK);
         assign rd_legal[b] = (st == BK_OPEN) && trcd_ok && !busy;
      end
   endgenerate

   ddr_rd_burst_seq #(.BA_W(BA_W), .CLW(CLW)) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (acc_rd),
      .start_ap   (is_rda),
      .start_bank (bank),
      .pre_req    (acc_pre),
      .pre_bank   (bank),
      .cas_lat    (cl_q),
      .beats      (beats_q),
      .busy       (busy),
      .rd_valid   (rd_valid),
      .rd_last    (rd_last),
      .burst_cut  (burst_cut),
      .rel_fire   (rel_fire),
      .rel_bank   (rel_bank)
   );
endmodule

// File: rtl/ddr_rd_bank_tracker_chk.sv
module ddr_rd_bank_tracker_chk
   import ddr_rd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2,
   parameter int CLW       = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [2:0]           cmd,
   input logic [BA_W-1:0]      bank,
   input logic [NUM_BANKS-1:0] rd_legal,
   input logic                 rd_valid,
   input logic                 rd_last,
   input logic                 burst_cut,
   input logic                 proto_err,
   input logic [NUM_BANKS-1:0] lock_vec,
   input logic [CLW-1:0]       cl_q,
   input logic [BW-1:0]        beats_q
);
   assert_last_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid);

   assert_cut_stops_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      burst_cut |-> !rd_valid);

   assert_no_read_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_legal == '0));

   assert_lock_refuses_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd >= 3'd1 && cmd <= 3'd4 && lock_vec[bank]) |=> proto_err);

   assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ($stable(cl_q) && $stable(beats_q)));

   assert_window_ends_cleanly_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_valid) |-> ($past(rd_last) || burst_cut));
endmodule

bind ddr_rd_bank_tracker ddr_rd_bank_tracker_chk #(
   .NUM_BANKS (NUM_BANKS),
   .BA_W      (BA_W),
   .CLW       (CLW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd       (cmd),
   .bank      (bank),
   .rd_legal  (rd_legal),
   .rd_valid  (rd_valid),
   .rd_last   (rd_last),
   .burst_cut (burst_cut),
   .proto_err (proto_err),
   .lock_vec  (lock_vec),
   .cl_q      (cl_q),
   .beats_q   (beats_q)
);

// File: tb/ddr_rd_bank_tracker_bench.sv
module ddr_rd_bank_tracker_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NB    = 4;
   localparam int TRCD  = 3;
   localparam int CLMIN = 2;
   localparam int CLMAX = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd = 3'd0;
   logic [1:0] bank = 2'd0;
   logic [2:0] cfg_cl = 3'd3;
   logic [1:0] cfg_bl = 2'd2;
   logic [NB-1:0] rd_legal;
   logic rd_valid, rd_last, burst_cut, proto_err;

   ddr_rd_bank_tracker #(.NUM_BANKS(NB), .TRCD(TRCD), .CL_MIN(CLMIN), .CL_MAX(CLMAX))
   u_ddr_rd_bank_tracker (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank),
      .cfg_cas_lat(cfg_cl), .cfg_burst_code(cfg_bl),
      .rd_legal(rd_legal), .rd_valid(rd_valid), .rd_last(rd_last),
      .burst_cut(burst_cut), .proto_err(proto_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit started = 0, finished = 0;

   // reference model state
   int m_st[NB];      // 0 idle, 1 open, 2 locked
   int m_since[NB];
   int m_busy = 0, m_lat = 0, m_beats = 0, m_bank = 0, m_ap = 0;
   int m_cut = 0, m_err = 0, m_cl = 2, m_nb = 4;

   function automatic int clamp_cl(int v);
      if (v < CLMIN) return CLMIN;
      if (v > CLMAX) return CLMAX;
      return v;
   endfunction

   function automatic int beats_of(int code);
      return (code == 0) ? 1 : (code == 1) ? 2 : 4;
   endfunction

   always @(posedge clk) begin
      int b, c, vld, last, legal, acc, cut;
      if (!rst_n) begin
         for (int i = 0; i < NB; i++) begin m_st[i] = 0; m_since[i] = 0; end
         m_busy = 0; m_lat = 0; m_beats = 0; m_cut = 0; m_err = 0; m_ap = 0;
         m_cl = clamp_cl(int'(cfg_cl));
         m_nb = beats_of(int'(cfg_bl));
      end else begin
         b = int'(bank); c = int'(cmd);
         vld   = (m_busy != 0 && m_lat == 0);
         last  = (vld && m_beats == 1);
         legal = (m_st[b] == 1 && m_since[b] >= TRCD && m_busy == 0);
         case (c)
            1: acc = (m_st[b] == 0);
            2, 3: acc = legal;
            4: acc = (m_st[b] != 2);
            default: acc = 1;
         endcase
         m_err = !acc;
         cut = (c == 4 && acc && m_busy != 0 && b == m_bank && !last);
         m_cut = cut;
         for (int i = 0; i < NB; i++)
            if (m_st[i] == 1 && m_since[i] < TRCD) m_since[i]++;
         if (m_busy != 0) begin
            if (cut) m_busy = 0;
            else if (m_lat > 0) m_lat--;
            else if (m_beats == 1) begin
               m_busy = 0;
               if (m_ap != 0) m_st[m_bank] = 0;
            end else m_beats--;
         end
         if (acc) begin
            case (c)
               1: begin m_st[b] = 1; m_since[b] = 1; end
               2, 3: begin
                  m_busy = 1; m_lat = m_cl - 1; m_beats = m_nb; m_bank = b;
                  m_ap = (c == 3);
                  if (c == 3) m_st[b] = 2;
               end
               4: m_st[b] = 0;
               default: ;
            endcase
         end
      end
      started = 1;
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      int e_leg, e_vld, e_last;
      if (started && !finished) begin
         e_leg = 0;
         for (int i = 0; i < NB; i++)
            if (m_st[i] == 1 && m_since[i] >= TRCD && m_busy == 0) e_leg |= (1 << i);
         e_vld  = (m_busy != 0 && m_lat == 0);
         e_last = (e_vld && m_beats == 1);
         // R1 holds through the reset cycles in the same comparisons
         chk(int'(rd_legal) == e_leg, "R3", "rd_legal", int'(rd_legal), e_leg);
         chk(int'(rd_valid) == e_vld, "R5", "rd_valid", int'(rd_valid), e_vld);
         chk(int'(rd_last) == e_last, "R6", "rd_last", int'(rd_last), e_last);
         chk(int'(burst_cut) == m_cut, "R7", "burst_cut", int'(burst_cut), m_cut);
         chk(int'(proto_err) == m_err, "R10", "proto_err", int'(proto_err), m_err);
      end
   end

   task automatic issue(int c, int b);
      @(negedge clk);
      cmd = 3'(c); bank = 2'(b);
   endtask

   task automatic nops(int n);
      repeat (n) issue(0, 0);
   endtask

   task automatic run_phase(int cl, int bl);
      int cle, nb, n;
      cle = clamp_cl(cl); nb = beats_of(bl);
      @(negedge clk);
      rst_n = 1'b0; cmd = 3'd0; cfg_cl = 3'(cl); cfg_bl = 2'(bl);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R4: later changes to the configuration must not matter
      cfg_cl = 3'(cl ^ 5); cfg_bl = ~2'(bl);
      // R2, R3: open, early read refused, legal read, read while busy refused
      issue(1, 0); issue(2, 0); nops(2); issue(2, 0); issue(2, 0); issue(1, 1);
      issue(1, 1); nops(10);
      // R7: close during latency phase cuts the burst
      issue(2, 0); issue(4, 0); nops(8);
      // R8: close to idle bank, then cut bank 1 in its data phase
      issue(2, 1); issue(4, 0); nops(cle - 1); issue(4, 1); nops(8);
      // R7 corner: close exactly on the final data cycle
      issue(1, 2); nops(3); issue(2, 2); nops(cle + nb - 2); issue(4, 2); nops(6);
      // R9, R10: auto-close lock, pokes while locked, reopen at release
      issue(1, 3); nops(3); issue(3, 3);
      n = cle + nb - 1;
      for (int i = 1; i < n; i++) issue((i % 3 == 1) ? 2 : (i % 3 == 2) ? 4 : 1, 3);
      issue(1, 3); issue(1, 3); nops(4);
      // unknown code is a no-op; reads on other banks after lock
      issue(7, 1); issue(2, 3); nops(3); issue(2, 3); nops(8);
      issue(4, 3); issue(4, 3); nops(3);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++; checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      run_phase(3, 2);
      run_phase(1, 0);
      run_phase(7, 3);
      run_phase(4, 1);
      run_phase(2, 2);
      nops(2);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule